// File: doc/BRIEF.md
# Grouped Four-Level Priority Interrupt Controller

This block arbitrates among 23 maskable interrupt lines and one non-maskable line on behalf of a CPU core. Each maskable line has its own enable bit, and a global enable gates all of them together. Priority is not set per line. The lines fall into six groups by index modulo 6, and each group carries a two-bit level. The two bits of that level sit in two separate registers.

When the block accepts a request, it raises `irq_o` and holds a 5-bit vector index and the accepted level until the CPU pulses `ack_i`. The acknowledge clears the global enable and marks the level as in service. A later `ret_i` pulse pops the highest in-service entry and sets the global enable again. Nesting works because a new maskable request is taken only when its level is strictly above every level already in service.

Each line can use level or edge detection. The non-maskable line is always edge-detected. It outranks everything, and neither the enables nor the in-service levels of maskable lines block it.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset `irq_o` is 0, and every register address reads 0: global enable off, all line enables off, all group levels 0, all lines in level mode.
- R2: Register map for 8-bit accesses:
  - Addresses 0 to 3 hold line enables in banks of six. Address a, bit b enables line 6a+b.
  - Bit 7 of address 0 is the global enable.
  - Address 4 holds the low level bit of each group and address 5 the high level bit, with bit g belonging to group g.
  - Addresses 6 to 8 hold trigger-mode bits in banks of eight. Address 6+k, bit b selects edge mode (1) for line 8k+b.
  - Bits with no line behind them read 0.
- R3: A maskable line is accepted only while both the global enable and its own enable bit are 1.
- R4: Line i belongs to group i mod 6, and its level is {high bit, low bit} of that group. Among eligible lines the highest level is accepted. Within one level the lowest index is accepted. `vec_o` carries the line index and `lvl_o` the level.
- R5: A rising edge on `nmi_i` is accepted as vector 23 at level 3. This happens even with the global enable at 0, and even while any maskable level is in service. It takes precedence over any maskable request.
- R6: While `irq_o` is 1 and `ack_i` is 0, `irq_o`, `vec_o` and `lvl_o` keep their values, even if the requesting line falls.
- R7: An acknowledge of a held request clears the global enable. A `ret_i` pulse sets it.
- R8: A maskable request is accepted only if its level is strictly above the highest level in service. `ret_i` removes the highest in-service entry, and the non-maskable entry counts as the highest.
- R9: A level-mode line is pending exactly while its input is 1. A pulse that ends before it could be accepted leaves nothing behind.
- R10: An edge-mode line latches a rising edge into a pending flag. An acknowledge of that line's vector clears the flag, but a rising edge in the same cycle as that acknowledge keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 23 | Maskable interrupt lines |
| nmi_i | input | 1 | Non-maskable interrupt line |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on address) |
| ack_i | input | 1 | CPU acknowledge of the held vector |
| ret_i | input | 1 | Return-from-interrupt pulse |
| irq_o | output | 1 | Request held for the CPU |
| vec_o | output | 5 | Vector index (0 to 22 maskable, 23 non-maskable) |
| lvl_o | output | 2 | Level of the held request |

## Verification
The acknowledge of an edge-mode line's vector can land in the same cycle as a fresh rising edge on that line. One step clears the pending flag and the other sets it. The bench drives the new edge in the very cycle that `ack_i` is high. It judges the outcome from the ports: after the following return, the same vector must be offered again. A second overlap is a pending non-maskable request meeting a held maskable one. It is provoked by raising `nmi_i` while a level-3 line's vector waits for its acknowledge, and it must come out as vector 23 right after that acknowledge.

// File: rtl/grp_irq_pkg.sv
`timescale 1ns/1ps
package grp_irq_pkg;
  localparam int LVL_W = 2;
  localparam int NLVL  = 1 << LVL_W;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/grp_irq_regs.sv
`timescale 1ns/1ps
module grp_irq_regs #(
  parameter int NSRC = 23,
  parameter int NGRP = 6,
  parameter int DW   = 8,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            ge_clr_i,
  input  logic            ge_set_i,
  output logic            ge_o,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] edge_o,
  output logic [NGRP-1:0] plo_o,
  output logic [NGRP-1:0] phi_o
);
  localparam int NBANK  = (NSRC + NGRP - 1) / NGRP;
  localparam int NTB    = (NSRC + DW - 1) / DW;
  localparam int PLO_A  = NBANK;
  localparam int PHI_A  = NBANK + 1;
  localparam int TRIG_A = NBANK + 2;

  logic [NSRC-1:0] en_q, en_d, tr_q, tr_d;
  logic [NGRP-1:0] plo_q, plo_d, phi_q, phi_d;
  logic            ge_q, ge_d;
  int              a;

  assign a = int'(addr_i);

  always_comb begin
    en_d  = en_q;
    tr_d  = tr_q;
    plo_d = plo_q;
    phi_d = phi_q;
    ge_d  = ge_q;
    if (ge_set_i) ge_d = 1'b1;
    if (ge_clr_i) ge_d = 1'b0;
    if (we_i) begin
      if (a < NBANK) begin
        for (int b = 0; b < NGRP; b++)
          if (a * NGRP + b < NSRC) en_d[a * NGRP + b] = wdata_i[b];
        if (a == 0) ge_d = wdata_i[DW-1];
      end else if (a == PLO_A) begin
        plo_d = wdata_i[NGRP-1:0];
      end else if (a == PHI_A) begin
        phi_d = wdata_i[NGRP-1:0];
      end else if (a >= TRIG_A && a < TRIG_A + NTB) begin
        for (int b = 0; b < DW; b++)
          if ((a - TRIG_A) * DW + b < NSRC) tr_d[(a - TRIG_A) * DW + b] = wdata_i[b];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (a < NBANK) begin
      for (int b = 0; b < NGRP; b++)
        if (a * NGRP + b < NSRC) rdata_o[b] = en_q[a * NGRP + b];
      if (a == 0) rdata_o[DW-1] = ge_q;
    end else if (a == PLO_A) begin
      rdata_o[NGRP-1:0] = plo_q;
    end else if (a == PHI_A) begin
      rdata_o[NGRP-1:0] = phi_q;
    end else if (a >= TRIG_A && a < TRIG_A + NTB) begin
      for (int b = 0; b < DW; b++)
        if ((a - TRIG_A) * DW + b < NSRC) rdata_o[b] = tr_q[(a - TRIG_A) * DW + b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      tr_q  <= '0;
      plo_q <= '0;
      phi_q <= '0;
      ge_q  <= 1'b0;
    end else begin
      if (we_i) begin
        en_q  <= en_d;
        tr_q  <= tr_d;
        plo_q <= plo_d;
        phi_q <= phi_d;
      end
      if (we_i || ge_set_i || ge_clr_i) ge_q <= ge_d;
    end
  end

  assign ge_o   = ge_q;
  assign en_o   = en_q;
  assign edge_o = tr_q;
  assign plo_o  = plo_q;
  assign phi_o  = phi_q;
endmodule

// File: rtl/grp_irq_detect.sv
`timescale 1ns/1ps
module grp_irq_detect #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] edge_mode_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic prev_q, flag_q, flag_d, rise;
    assign rise = line_i[i] & ~prev_q;
    always_comb begin
      if (edge_mode_i[i]) flag_d = (flag_q & ~clr_i[i]) | rise;
      else                flag_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        prev_q <= line_i[i];
        flag_q <= flag_d;
      end
    end
    assign pend_o[i] = edge_mode_i[i] ? flag_q : line_i[i];
  end
endmodule

// File: rtl/grp_irq_arb.sv
`timescale 1ns/1ps
module grp_irq_arb
  import grp_irq_pkg::*;
#(
  parameter int NSRC  = 23,
  parameter int NGRP  = 6,
  parameter int IDX_W = 5
) (
  input  logic [NSRC-1:0]  elig_i,
  input  logic [NGRP-1:0]  plo_i,
  input  logic [NGRP-1:0]  phi_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output lvl_t             lvl_o
);
  logic [NSRC-1:0] hit [NLVL];
  logic [NLVL-1:0] lvl_any;
  logic [NSRC-1:0] sel;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    lvl_t src_lvl;
    assign src_lvl = {phi_i[i % NGRP], plo_i[i % NGRP]};
    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      assign hit[l][i] = elig_i[i] && (src_lvl == lvl_t'(l));
    end
  end

  for (genvar l = 0; l < NLVL; l++) begin : g_any
    assign lvl_any[l] = |hit[l];
  end

  always_comb begin
    any_o = |lvl_any;
    lvl_o = '0;
    for (int l = 0; l < NLVL; l++)
      if (lvl_any[l]) lvl_o = lvl_t'(l);
    sel   = hit[lvl_o];
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (sel[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/grp_irq_ctrl.sv
`timescale 1ns/1ps
module grp_irq_ctrl
  import grp_irq_pkg::*;
#(
  parameter int NSRC = 23,
  parameter int NGRP = 6,
  parameter int DW   = 8,
  parameter int AW   = 4,
  parameter int VW   = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            nmi_i,
  input  logic            reg_we_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  input  logic            ack_i,
  input  logic            ret_i,
  output logic            irq_o,
  output logic [VW-1:0]   vec_o,
  output logic [1:0]      lvl_o
);
  localparam logic [VW-1:0] NMI_V = VW'(NSRC);

  logic            ge, any, ack_hit, take, nmi_ok, msk_ok;
  logic [NSRC-1:0] en, trig, elig;
  logic [NGRP-1:0] plo, phi;
  logic [NSRC:0]   pend, clr;
  logic [VW-1:0]   best_idx;
  lvl_t            best_lvl;
  logic [2:0]      cur;

  logic            irq_q, irq_d;
  logic [VW-1:0]   vec_q, vec_d;
  lvl_t            lvl_q, lvl_d;
  logic [NLVL-1:0] isr_q;
  logic            nmi_isr_q;
  logic [NLVL:0]   stk, stk_d;

  assign ack_hit = irq_q && ack_i;

  grp_irq_regs #(.NSRC(NSRC), .NGRP(NGRP), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .ge_clr_i(ack_hit), .ge_set_i(ret_i), .ge_o(ge),
    .en_o(en), .edge_o(trig), .plo_o(plo), .phi_o(phi)
  );

  for (genvar i = 0; i <= NSRC; i++) begin : g_clr
    assign clr[i] = ack_hit && (vec_q == VW'(i));
  end

  grp_irq_detect #(.N(NSRC + 1)) u_det (
    .clk(clk), .rst_n(rst_n),
    .line_i({nmi_i, src_i}), .edge_mode_i({1'b1, trig}),
    .clr_i(clr), .pend_o(pend)
  );

  assign elig = pend[NSRC-1:0] & en & {NSRC{ge}};

  grp_irq_arb #(.NSRC(NSRC), .NGRP(NGRP), .IDX_W(VW)) u_arb (
    .elig_i(elig), .plo_i(plo), .phi_i(phi),
    .any_o(any), .idx_o(best_idx), .lvl_o(best_lvl)
  );

  assign stk = {nmi_isr_q, isr_q};

  always_comb begin
    cur = 3'd0;
    for (int b = 0; b <= NLVL; b++)
      if (stk[b]) cur = 3'(b + 1);
  end

  assign nmi_ok = pend[NSRC] && !nmi_isr_q;
  assign msk_ok = any && (({1'b0, best_lvl} + 3'd1) > cur);
  assign take   = !irq_q && (nmi_ok || msk_ok);

  always_comb begin
    stk_d = stk;
    if (ret_i) begin
      for (int b = NLVL; b >= 0; b--)
        if (stk[b] && (stk_d == stk)) stk_d[b] = 1'b0;
    end
    if (ack_hit) begin
      if (vec_q == NMI_V) stk_d[NLVL] = 1'b1;
      else                stk_d[lvl_q] = 1'b1;
    end
  end

  always_comb begin
    irq_d = irq_q;
    vec_d = vec_q;
    lvl_d = lvl_q;
    if (ack_hit) begin
      irq_d = 1'b0;
    end else if (take) begin
      irq_d = 1'b1;
      if (nmi_ok) begin
        vec_d = NMI_V;
        lvl_d = lvl_t'(NLVL - 1);
      end else begin
        vec_d = best_idx;
        lvl_d = best_lvl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q     <= 1'b0;
      vec_q     <= '0;
      lvl_q     <= '0;
      isr_q     <= '0;
      nmi_isr_q <= 1'b0;
    end else begin
      if (ack_hit || take) begin
        irq_q <= irq_d;
        vec_q <= vec_d;
        lvl_q <= lvl_d;
      end
      if (ack_hit || ret_i) begin
        isr_q     <= stk_d[NLVL-1:0];
        nmi_isr_q <= stk_d[NLVL];
      end
    end
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;
  assign lvl_o = lvl_q;
endmodule

// File: rtl/grp_irq_ctrl_chk.sv
`timescale 1ns/1ps
module grp_irq_ctrl_chk #(
  parameter int NSRC = 23,
  parameter int VW   = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_o,
  input logic [VW-1:0] vec_o,
  input logic [1:0]    lvl_o,
  input logic          ack_i,
  input logic          ret_i,
  input logic          reg_we_i,
  input logic          ge,
  input logic [4:0]    stk
);
  localparam logic [VW-1:0] NMI_V = VW'(NSRC);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !ack_i |=> irq_o && $stable(vec_o) && $stable(lvl_o));

  p_ack_clears_ge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && ack_i && !reg_we_i |=> !ge);

  p_ret_sets_ge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i && !(irq_o && ack_i) && !reg_we_i |=> ge);

  p_mask_needs_ge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) && (vec_o != NMI_V) |-> $past(ge));

  p_ret_pops_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i && !(irq_o && ack_i) && (stk != 5'd0)
    |=> ($countones(stk) + 1) == $countones($past(stk)));

  p_nmi_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && (vec_o == NMI_V) |-> lvl_o == 2'd3);

  p_vec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> vec_o <= NMI_V);
endmodule

bind grp_irq_ctrl grp_irq_ctrl_chk #(.NSRC(NSRC), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .vec_o(vec_o), .lvl_o(lvl_o),
  .ack_i(ack_i), .ret_i(ret_i), .reg_we_i(reg_we_i), .ge(ge),
  .stk({nmi_isr_q, isr_q})
);

// File: tb/grp_irq_ctrl_bench.sv
`timescale 1ns/1ps
module grp_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [22:0] src_i;
  logic        nmi_i, reg_we_i, ack_i, ret_i;
  logic [3:0]  reg_addr_i;
  logic [7:0]  reg_wdata_i, reg_rdata_o;
  logic        irq_o;
  logic [4:0]  vec_o;
  logic [1:0]  lvl_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  grp_irq_ctrl u_grp_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .nmi_i(nmi_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .ack_i(ack_i), .ret_i(ret_i),
    .irq_o(irq_o), .vec_o(vec_o), .lvl_o(lvl_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = 4'(a); reg_wdata_i = 8'(d);
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input int exp);
    @(negedge clk);
    reg_addr_i = 4'(a);
    #1 chk(req, int'(reg_rdata_o), exp);
  endtask

  task automatic ack();
    @(negedge clk); ack_i = 1'b1;
    @(negedge clk); ack_i = 1'b0;
  endtask

  task automatic ret();
    @(negedge clk); ret_i = 1'b1;
    @(negedge clk); ret_i = 1'b0;
  endtask

  task automatic req_chk(input string req, input int v, input int l);
    chk({req, " irq"}, int'(irq_o), 1);
    chk({req, " vec"}, int'(vec_o), v);
    chk({req, " lvl"}, int'(lvl_o), l);
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", int'(irq_o), 0);
    for (int a = 0; a < 9; a++) rd_chk("R1 register reset", a, 0);
  endtask

  task automatic t_regmap();
    wr(0, 8'h3F); rd_chk("R2 enable bank 0", 0, 8'h3F);
    wr(0, 8'h80); rd_chk("R2 global enable bit", 0, 8'h80);
    wr(3, 8'hFF); rd_chk("R2 last enable bank", 3, 8'h1F);
    wr(4, 8'hFF); rd_chk("R2 low level bits", 4, 8'h3F);
    wr(5, 8'h2A); rd_chk("R2 high level bits", 5, 8'h2A);
    wr(8, 8'hFF); rd_chk("R2 last trigger bank", 8, 8'h7F);
    for (int a = 0; a < 9; a++) wr(a, 0);
    rd_chk("R2 cleared", 3, 0);
  endtask

  task automatic t_gating();
    wr(0, 8'h04);
    src_i[2] = 1'b1; tick(3);
    chk("R3 global enable off", int'(irq_o), 0);
    wr(0, 8'h84); tick(2);
    req_chk("R3 enabled line", 2, 0);
    ack();
    rd_chk("R7 ack clears global enable", 0, 8'h04);
    chk("R7 irq dropped by ack", int'(irq_o), 0);
    src_i[2] = 1'b0;
    ret();
    rd_chk("R7 return sets global enable", 0, 8'h84);
    src_i[3] = 1'b1; tick(3);
    chk("R3 line enable off", int'(irq_o), 0);
    src_i[3] = 1'b0;
  endtask

  task automatic t_priority();
    wr(4, 8'h11); wr(5, 8'h12);
    wr(1, 8'h3F); wr(2, 8'h3F); wr(3, 8'h1F); wr(0, 8'hBF);
    @(negedge clk);
    src_i[0] = 1'b1; src_i[7] = 1'b1; src_i[13] = 1'b1; src_i[22] = 1'b1; src_i[10] = 1'b1;
    tick(2);
    req_chk("R4 highest level lowest index", 10, 3);
    ack(); src_i[10] = 1'b0; ret(); tick(1);
    req_chk("R4 second level-3 line", 22, 3);
    ack(); src_i[22] = 1'b0; ret(); tick(1);
    req_chk("R4 level 2 lower index", 7, 2);
    ack(); src_i[7] = 1'b0; src_i[13] = 1'b0; ret(); tick(1);
    req_chk("R4 level 1 group 0", 0, 1);
    ack(); src_i[0] = 1'b0; ret(); tick(2);
    chk("R4 nothing left", int'(irq_o), 0);
  endtask

  task automatic t_nest();
    @(negedge clk); src_i[0] = 1'b1; tick(2);
    req_chk("R8 first level", 0, 1);
    ack(); wr(0, 8'hBF);
    @(negedge clk); src_i[6] = 1'b1; tick(3);
    chk("R8 equal level blocked", int'(irq_o), 0);
    @(negedge clk); src_i[7] = 1'b1; tick(2);
    req_chk("R8 higher level preempts", 7, 2);
    ack(); src_i[7] = 1'b0; wr(0, 8'hBF); tick(3);
    chk("R8 lower levels blocked", int'(irq_o), 0);
    ret(); tick(2);
    chk("R8 return pops top only", int'(irq_o), 0);
    ret(); tick(1);
    req_chk("R8 resumed after pop", 0, 1);
    ack(); src_i[0] = 1'b0; src_i[6] = 1'b0; ret(); tick(2);
    chk("R8 idle", int'(irq_o), 0);
  endtask

  task automatic t_nmi();
    @(negedge clk); src_i[22] = 1'b1; tick(2);
    req_chk("R6 level-3 held", 22, 3);
    @(negedge clk); nmi_i = 1'b1; tick(3);
    req_chk("R6 still held", 22, 3);
    ack(); tick(2);
    req_chk("R5 nmi over in-service level 3", 23, 3);
    src_i[22] = 1'b0; nmi_i = 1'b0;
    ack(); ret(); ret(); tick(2);
    chk("R5 idle", int'(irq_o), 0);
    wr(0, 8'h3F);
    @(negedge clk); nmi_i = 1'b1; tick(3);
    req_chk("R5 nmi with global enable off", 23, 3);
    ack(); nmi_i = 1'b0; ret(); tick(2);
    chk("R5 idle again", int'(irq_o), 0);
  endtask

  task automatic t_edge();
    wr(1, 0); wr(2, 0); wr(3, 0); wr(0, 8'h20); wr(6, 8'h20);
    @(negedge clk); src_i[5] = 1'b1;
    @(negedge clk); src_i[5] = 1'b0; tick(3);
    chk("R10 latched while masked", int'(irq_o), 0);
    wr(0, 8'hA0); tick(2);
    req_chk("R10 latched edge served", 5, 0);
    @(negedge clk); ack_i = 1'b1; src_i[5] = 1'b1;
    @(negedge clk); ack_i = 1'b0; tick(3);
    chk("R10 masked after ack", int'(irq_o), 0);
    ret(); tick(1);
    req_chk("R10 edge in ack cycle kept", 5, 0);
    ack(); ret(); tick(3);
    chk("R10 flag cleared by ack", int'(irq_o), 0);
    src_i[5] = 1'b0;
    wr(0, 8'h08);
    @(negedge clk); src_i[3] = 1'b1; tick(2); src_i[3] = 1'b0;
    wr(0, 8'h88); tick(3);
    chk("R9 level pulse leaves nothing", int'(irq_o), 0);
    @(negedge clk); src_i[3] = 1'b1; tick(2);
    req_chk("R9 level line pending", 3, 0);
    src_i[3] = 1'b0; tick(3);
    req_chk("R6 held after line falls", 3, 0);
    ack(); ret(); tick(2);
    chk("R9 idle", int'(irq_o), 0);
  endtask

  initial begin
    rst_n = 1'b0; src_i = '0; nmi_i = 1'b0; reg_we_i = 1'b0;
    reg_addr_i = '0; reg_wdata_i = '0; ack_i = 1'b0; ret_i = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_regmap();
    t_gating();
    t_priority();
    t_nest();
    t_nmi();
    t_edge();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule